// File: doc/BRIEF.md
# Antenna Dwell Timer with RSSI Sample Strobe

This block paces a two-antenna diversity receiver. A prescaler turns the system clock into a coarse tick of 20 or 40 clocks. A down-counter measures how long the receiver listens on each antenna, counted in those ticks. When a dwell period runs out, the antenna-select output flips, a one-cycle switch pulse is issued and the counter reloads.

Inside each dwell, the block issues a one-cycle conversion-start strobe to a signal-strength A/D converter. The strobe comes a programmed number of ticks before the coming antenna switch, so the sample describes the antenna that is about to be left. An offset of zero turns this strobe off. In external-start mode the internal offset plays no part. Instead, every rising edge of an asynchronous start pin produces one strobe, after a two-flop synchronizer.

The offset must leave room for the conversion and a small guard time before the dwell ends. A dwell period that starts with a configuration breaking that rule produces no internal strobe, and a sticky error flag is set. The flag clears only on reset.

Top module: `ant_dwell_timer`

## Requirements
- R1: The timer advances once every 20 clocks when `tick_sel_i` is 0 and once every 40 clocks when it is 1, so all dwell and offset intervals at the outputs are whole multiples of that tick.
- R2: With a nonzero dwell length L, consecutive `switch_pulse_o` pulses are L ticks apart. Each pulse is one cycle wide and coincides with a change of `ant_sel_o`. `ant_sel_o` does not change at any other time.
- R3: With internal sampling (`ext_mode_i` = 0, offset S nonzero, constraint met), one single-cycle `conv_start_o` strobe occurs in each dwell, exactly S ticks before the next switch pulse.
- R4: An offset of 0 with `ext_mode_i` = 0 produces no `conv_start_o` strobe at all.
- R5: With `ext_mode_i` = 1, each rising edge of `ext_start_i` produces exactly one single-cycle strobe after a fixed latency, however long the pin stays high, and the internal offset produces no strobe.
- R6: With `ext_mode_i` = 0, activity on `ext_start_i` produces no strobe.
- R7: A dwell starts with the constraint broken when (S + C) x tick + guard >= L x tick, where C is the conversion time, the guard is 9 clocks for the 20-clock tick and 18 clocks for the 40-clock tick, S is nonzero and `ext_mode_i` = 0. Such a dwell produces no strobe, and `cfg_err_o` is set.
- R8: `cfg_err_o` stays 1 once set, even after the configuration is corrected, until reset.
- R9: A dwell length of 0 stops the timer. No switch pulse occurs and `ant_sel_o` holds its value.
- R10: During and directly after reset, `ant_sel_o`, `switch_pulse_o`, `conv_start_o` and `cfg_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| dwell_len_i | input | 6 | Dwell length in ticks; 0 stops the timer |
| samp_ofs_i | input | 6 | Ticks before dwell end at which to sample; 0 disables |
| conv_time_i | input | 4 | A/D conversion time in ticks (constraint only) |
| tick_sel_i | input | 1 | 0: 20-clock tick, 1: 40-clock tick |
| ext_mode_i | input | 1 | 1: conversions started by external pin edges |
| ext_start_i | input | 1 | Asynchronous external conversion start |
| ant_sel_o | output | 1 | Selected antenna |
| switch_pulse_o | output | 1 | One-cycle pulse at each antenna change |
| conv_start_o | output | 1 | One-cycle A/D conversion-start strobe |
| cfg_err_o | output | 1 | Sticky timing-constraint violation flag |

## Verification
The hardest situation to reach from the ports is the edge of the timing constraint, because the guard term is far smaller than one tick. The stimulus therefore pairs a configuration that just meets the constraint (offset 4, conversion 1, dwell 6) with one that just breaks it (dwell 5). A scoreboard then checks that strobes appear in the first case and not in the second. Stickiness is shown by correcting the offset after the violation, waiting several dwells and reading the flag again.

// File: rtl/ant_dwell_pkg.sv
package ant_dwell_pkg;
    parameter int unsigned DWELL_W  = 6;
    parameter int unsigned OFS_W    = 6;
    parameter int unsigned CONV_W   = 4;
    parameter int unsigned DIV_LO   = 20;
    parameter int unsigned DIV_HI   = 40;
    parameter int unsigned GUARD_LO = 9;
    parameter int unsigned GUARD_HI = 18;
    parameter int unsigned SYNC_STG = 2;
endpackage

// File: rtl/adt_tick_gen.sv
module adt_tick_gen #(
    parameter int unsigned DIV_LO = ant_dwell_pkg::DIV_LO,
    parameter int unsigned DIV_HI = ant_dwell_pkg::DIV_HI
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    output logic tick_o
);
    localparam int unsigned PW = $clog2(DIV_HI);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_q, st_d;
    logic [PW-1:0] limit;

    always_comb begin
        st_d   = st_q;
        limit  = sel_i ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
        tick_o = (st_q.cnt >= limit);
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= PW'(DIV_HI - 1));
endmodule

// File: rtl/adt_ext_edge.sv
module adt_ext_edge #(
    parameter int unsigned STAGES = ant_dwell_pkg::SYNC_STG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_st_t;

    sync_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin_i};
        st_d.prev = st_q.sh[STAGES-1];
        rise_o    = st_q.sh[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/adt_cfg_check.sv
module adt_cfg_check #(
    parameter int unsigned DWELL_W  = ant_dwell_pkg::DWELL_W,
    parameter int unsigned OFS_W    = ant_dwell_pkg::OFS_W,
    parameter int unsigned CONV_W   = ant_dwell_pkg::CONV_W,
    parameter int unsigned DIV_LO   = ant_dwell_pkg::DIV_LO,
    parameter int unsigned DIV_HI   = ant_dwell_pkg::DIV_HI,
    parameter int unsigned GUARD_LO = ant_dwell_pkg::GUARD_LO,
    parameter int unsigned GUARD_HI = ant_dwell_pkg::GUARD_HI
) (
    input  logic [DWELL_W-1:0] dwell_len_i,
    input  logic [OFS_W-1:0]   samp_ofs_i,
    input  logic [CONV_W-1:0]  conv_time_i,
    input  logic               tick_sel_i,
    output logic               viol_o
);
    localparam int unsigned SPAN = ((2**OFS_W) + (2**CONV_W) + (2**DWELL_W)) * DIV_HI + GUARD_HI;
    localparam int unsigned TW   = $clog2(SPAN) + 1;

    logic [TW-1:0] div_w, guard_w, need_w, have_w;

    always_comb begin
        div_w   = tick_sel_i ? TW'(DIV_HI)   : TW'(DIV_LO);
        guard_w = tick_sel_i ? TW'(GUARD_HI) : TW'(GUARD_LO);
        need_w  = (TW'(samp_ofs_i) + TW'(conv_time_i)) * div_w + guard_w;
        have_w  = TW'(dwell_len_i) * div_w;
        viol_o  = (need_w >= have_w);
    end
endmodule

// File: rtl/adt_dwell_core.sv
module adt_dwell_core #(
    parameter int unsigned DWELL_W = ant_dwell_pkg::DWELL_W,
    parameter int unsigned OFS_W   = ant_dwell_pkg::OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [DWELL_W-1:0] dwell_len_i,
    input  logic [OFS_W-1:0]   samp_ofs_i,
    input  logic               ext_mode_i,
    input  logic               ext_rise_i,
    input  logic               viol_i,
    output logic               ant_o,
    output logic               switch_o,
    output logic               conv_o,
    output logic               err_o
);
    localparam int unsigned MW = (DWELL_W > OFS_W) ? DWELL_W : OFS_W;

    typedef struct packed {
        logic [DWELL_W-1:0] rem;
        logic               ant;
        logic               sw;
        logic               conv;
        logic               bad;
        logic               err;
    } core_st_t;

    core_st_t st_q, st_d;
    logic [DWELL_W-1:0] rem_dec;
    logic               arm_viol;
    logic               ofs_hit;

    always_comb begin
        st_d     = st_q;
        st_d.sw   = 1'b0;
        st_d.conv = 1'b0;
        rem_dec  = st_q.rem - 1'b1;
        arm_viol = viol_i && (samp_ofs_i != '0) && !ext_mode_i;
        ofs_hit  = !ext_mode_i && (samp_ofs_i != '0) && !st_q.bad &&
                   (MW'(rem_dec) == MW'(samp_ofs_i));

        if (tick_i && (dwell_len_i != '0)) begin
            if (st_q.rem == '0) begin
                st_d.rem = dwell_len_i;
                st_d.bad = arm_viol;
                st_d.err = st_q.err | arm_viol;
            end else if (st_q.rem == DWELL_W'(1)) begin
                st_d.rem = dwell_len_i;
                st_d.ant = ~st_q.ant;
                st_d.sw  = 1'b1;
                st_d.bad = arm_viol;
                st_d.err = st_q.err | arm_viol;
            end else begin
                st_d.rem  = rem_dec;
                st_d.conv = ofs_hit;
            end
        end

        if (ext_mode_i) st_d.conv = ext_rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ant_o    = st_q.ant;
    assign switch_o = st_q.sw;
    assign conv_o   = st_q.conv;
    assign err_o    = st_q.err;

    assert_switch_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sw |-> $past(tick_i));
    assert_ant_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sw |-> (st_q.ant != $past(st_q.ant)));
    assert_ant_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.sw |-> (st_q.ant == $past(st_q.ant)));
    assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.conv |=> !st_q.conv);
    assert_zero_ofs_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.conv && !$past(ext_mode_i)) |-> ($past(samp_ofs_i) != '0));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_q.err) |-> st_q.err);
    assert_zero_len_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dwell_len_i) == '0) |-> !st_q.sw);
endmodule

// File: rtl/ant_dwell_timer.sv
module ant_dwell_timer #(
    parameter int unsigned DWELL_W  = ant_dwell_pkg::DWELL_W,
    parameter int unsigned OFS_W    = ant_dwell_pkg::OFS_W,
    parameter int unsigned CONV_W   = ant_dwell_pkg::CONV_W,
    parameter int unsigned DIV_LO   = ant_dwell_pkg::DIV_LO,
    parameter int unsigned DIV_HI   = ant_dwell_pkg::DIV_HI,
    parameter int unsigned GUARD_LO = ant_dwell_pkg::GUARD_LO,
    parameter int unsigned GUARD_HI = ant_dwell_pkg::GUARD_HI,
    parameter int unsigned SYNC_STG = ant_dwell_pkg::SYNC_STG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DWELL_W-1:0] dwell_len_i,
    input  logic [OFS_W-1:0]   samp_ofs_i,
    input  logic [CONV_W-1:0]  conv_time_i,
    input  logic               tick_sel_i,
    input  logic               ext_mode_i,
    input  logic               ext_start_i,
    output logic               ant_sel_o,
    output logic               switch_pulse_o,
    output logic               conv_start_o,
    output logic               cfg_err_o
);
    logic tick_w;
    logic rise_w;
    logic viol_w;

    adt_tick_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (tick_sel_i),
        .tick_o (tick_w)
    );

    adt_ext_edge #(.STAGES(SYNC_STG)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_start_i),
        .rise_o (rise_w)
    );

    adt_cfg_check #(
        .DWELL_W(DWELL_W), .OFS_W(OFS_W), .CONV_W(CONV_W),
        .DIV_LO(DIV_LO), .DIV_HI(DIV_HI),
        .GUARD_LO(GUARD_LO), .GUARD_HI(GUARD_HI)
    ) chk_i (
        .dwell_len_i (dwell_len_i),
        .samp_ofs_i  (samp_ofs_i),
        .conv_time_i (conv_time_i),
        .tick_sel_i  (tick_sel_i),
        .viol_o      (viol_w)
    );

    adt_dwell_core #(.DWELL_W(DWELL_W), .OFS_W(OFS_W)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_w),
        .dwell_len_i (dwell_len_i),
        .samp_ofs_i  (samp_ofs_i),
        .ext_mode_i  (ext_mode_i),
        .ext_rise_i  (rise_w),
        .viol_i      (viol_w),
        .ant_o       (ant_sel_o),
        .switch_o    (switch_pulse_o),
        .conv_o      (conv_start_o),
        .err_o       (cfg_err_o)
    );

    assert_ext_mode_no_switch_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start_o && $past(ext_mode_i)) |-> $past(rise_w));
endmodule

// File: tb/ant_dwell_timer_tb_top.sv
`timescale 1ns/1ps
module ant_dwell_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] dwell_len = '0;
    logic [5:0] samp_ofs = '0;
    logic [3:0] conv_time = '0;
    logic       tick_sel = 1'b0;
    logic       ext_mode = 1'b0;
    logic       ext_start = 1'b0;
    logic       ant_sel, switch_pulse, conv_start, cfg_err;

    always #2.5 clk = ~clk;

    ant_dwell_timer dut_i (
        .clk(clk), .rst_n(rst_n), .dwell_len_i(dwell_len), .samp_ofs_i(samp_ofs),
        .conv_time_i(conv_time), .tick_sel_i(tick_sel), .ext_mode_i(ext_mode),
        .ext_start_i(ext_start), .ant_sel_o(ant_sel), .switch_pulse_o(switch_pulse),
        .conv_start_o(conv_start), .cfg_err_o(cfg_err)
    );

    typedef struct {
        bit    is_sw;
        int    gap;
        bit    ant;
        string req;
    } item_t;

    item_t q[$];
    int  n_cmp = 0;
    int  n_bad = 0;
    int  since = 0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;

    task automatic chk(bit ok, string req, int act, int exp, string what);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(bit is_sw, int gap, bit ant, string req);
        item_t it;
        it.is_sw = is_sw; it.gap = gap; it.ant = ant; it.req = req;
        q.push_back(it);
    endtask

    // Expected sequence for internal sampling: strobe S ticks before each switch.
    task automatic push_int(int len, int ofs, int dv, int n, string req);
        for (int i = 0; i < n; i++) begin
            if (ofs != 0) push(1'b0, (i == 0) ? -1 : (len - ofs) * dv, 1'b0, req);
            push(1'b1, (ofs != 0) ? ofs * dv : ((i == 0) ? -1 : len * dv), bit'((i + 1) % 2), req);
        end
    endtask

    task automatic take(bit is_sw);
        item_t it;
        if (q.size() == 0) begin
            chk(1'b0, is_sw ? "R2" : "R3", int'(is_sw), -1, "unexpected event");
            return;
        end
        it = q.pop_front();
        chk(it.is_sw == is_sw, it.req, int'(is_sw), int'(it.is_sw), "event kind (1=switch)");
        if (it.gap >= 0) chk(since == it.gap, it.req, since, it.gap, "cycles since previous event");
        if (is_sw && it.is_sw) chk(ant_sel == it.ant, it.req, int'(ant_sel), int'(it.ant), "antenna after switch");
    endtask

    // Monitor: pops expected items as events appear
    always @(negedge clk) begin
        if (!rst_n) since = 0;
        else begin
            since++;
            if (mon_on && conv_start) take(1'b0);
            if (mon_on && switch_pulse) take(1'b1);
            if (conv_start || switch_pulse) since = 0;
        end
    end

    task automatic do_reset();
        mon_on = 1'b0;
        rst_n  = 1'b0;
        q.delete();
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;
    endtask

    task automatic drain(int limit, string req);
        int t = 0;
        while (q.size() != 0 && t < limit) begin
            @(negedge clk);
            t++;
        end
        chk(q.size() == 0, req, q.size(), 0, "items left after wait");
        mon_on = 1'b0;
    endtask

    task automatic cfg(int len, int ofs, int cv, bit ts, bit em);
        dwell_len = 6'(len); samp_ofs = 6'(ofs); conv_time = 4'(cv);
        tick_sel = ts; ext_mode = em;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(150000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R10: reset values
        cfg(10, 3, 2, 1'b0, 1'b0);
        @(negedge clk);
        chk({ant_sel, switch_pulse, conv_start, cfg_err} == 4'b0, "R10",
            {ant_sel, switch_pulse, conv_start, cfg_err}, 0, "outputs in reset");
        do_reset();
        chk({ant_sel, switch_pulse, conv_start, cfg_err} == 4'b0, "R10",
            {ant_sel, switch_pulse, conv_start, cfg_err}, 0, "outputs after reset");

        // R2/R3: L=10, S=3, 20-clock tick
        push_int(10, 3, 20, 3, "R3");
        drain(2000, "R3");
        chk(cfg_err == 1'b0, "R7", cfg_err, 0, "no error for valid config");

        // R1: 40-clock tick, L=6, S=2, C=1
        cfg(6, 2, 1, 1'b1, 1'b0);
        do_reset();
        push_int(6, 2, 40, 3, "R1");
        drain(3000, "R1");

        // R4 and R6: offset 0, external pin toggled but not selected
        cfg(4, 0, 0, 1'b0, 1'b0);
        do_reset();
        push_int(4, 0, 20, 4, "R6");
        for (int k = 0; k < 20; k++) begin
            ext_start = 1'b1; repeat (6) @(negedge clk);
            ext_start = 1'b0; repeat (6) @(negedge clk);
        end
        drain(1000, "R4");

        // R7 boundary: just meets the constraint, strobes present
        cfg(6, 4, 1, 1'b0, 1'b0);
        do_reset();
        push_int(6, 4, 20, 3, "R7");
        drain(2000, "R7");
        chk(cfg_err == 1'b0, "R7", cfg_err, 0, "flag at boundary-ok config");

        // R7 violation: just breaks it, switches only
        cfg(5, 4, 1, 1'b0, 1'b0);
        do_reset();
        push_int(5, 0, 20, 3, "R7");
        drain(2000, "R7");
        chk(cfg_err == 1'b1, "R7", cfg_err, 1, "flag after violation");

        // R8: stays set after correcting the config
        samp_ofs = 6'd0;
        repeat (400) @(negedge clk);
        chk(cfg_err == 1'b1, "R8", cfg_err, 1, "flag sticky");
        do_reset();
        chk(cfg_err == 1'b0, "R8", cfg_err, 0, "flag cleared by reset");

        // R5 and R9: external mode, timer stopped
        cfg(0, 3, 0, 1'b0, 1'b1);
        do_reset();
        push(1'b0, -1, 1'b0, "R5");
        push(1'b0, 12, 1'b0, "R5");
        push(1'b0, 12, 1'b0, "R5");
        for (int k = 0; k < 3; k++) begin
            ext_start = 1'b1; repeat (6) @(negedge clk);
            ext_start = 1'b0; repeat (6) @(negedge clk);
        end
        drain(200, "R5");
        mon_on = 1'b1;
        repeat (400) @(negedge clk);
        mon_on = 1'b0;
        chk(ant_sel == 1'b0, "R9", ant_sel, 0, "antenna held with zero length");

        // R5: long high level gives one strobe
        do_reset();
        push(1'b0, -1, 1'b0, "R5");
        ext_start = 1'b1; repeat (100) @(negedge clk);
        ext_start = 1'b0; repeat (10) @(negedge clk);
        drain(10, "R5");

        // R5: internal offset ignored in external mode
        cfg(8, 3, 0, 1'b0, 1'b1);
        do_reset();
        push_int(8, 0, 20, 3, "R5");
        drain(2000, "R5");

        summary();
    end
endmodule